// File: doc/BRIEF.md
# Cascadable Event Counter Pair

The block holds two 8-bit counter channels that, with the cascade bit set, act as one 16-bit counter of edges on an external pulse input. The lower channel holds count bits 7:0 and the upper channel holds bits 15:8. The pulse input passes through a two-flop synchroniser before the edge detector. A select bit chooses whether rising or falling edges are counted. Two byte-wide compare registers together form a 16-bit compare value N.

Each time the count equals N on a counted edge, the counter returns to zero and a one-cycle interrupt pulse is raised. The interrupt therefore comes on the (N+1)th counted edge and repeats after that. Software starts the pair by enabling the upper channel first and then the lower one, and stops it by clearing the lower enable first. While counting is active, writes to the compare registers are refused and a sticky error flag is raised. All registers and the live count are reached through a byte-wide write/read port.

Register map (3-bit address, 8-bit data):

| Address | Content |
|---|---|
| 0 | lower control: bit 0 = lower enable; read bit 7 = error flag; write 1 to bit 7 to clear it |
| 1 | upper control: bit 0 = upper enable, bit 1 = cascade |
| 2 | lower edge select: bit 0 |
| 3 | upper edge select: 8-bit, stored only |
| 4 | compare bits 7:0 |
| 5 | compare bits 15:8 |
| 6 | count bits 7:0, read-only |
| 7 | count bits 15:8, read-only |

Top module: `cascade_event_counter`

## Requirements
- R1: After reset, all eight register addresses read 00h and matchIrq is 0.
- R2: A write of 1 to bit 0 of address 0 sets the lower enable only if bit 0 of address 1 (upper enable) is already 1. Otherwise the lower enable stays 0, and address 0 bit 0 reads 0.
- R3: The count advances only while the lower enable, the upper enable and the cascade bit (address 1 bit 1) are all 1. If any of them is 0, the count holds its value and is not cleared.
- R4: With address 2 bit 0 at 1, rising edges of pulseIn are counted. With it at 0, falling edges are counted.
- R5: The count is 16 bits wide. Address 6 reads bits 7:0 and address 7 reads bits 15:8. A counted edge with the count below N adds one, with carry from the low byte into the high byte.
- R6: A counted edge that finds the count equal to N = {address 5, address 4} clears the count to 0000h. On that same clock edge matchIrq is set high for exactly one cycle. The pulse repeats every N+1 counted edges, and N = 0 gives a pulse on every counted edge.
- R7: A write to address 4 or 5 while counting is active leaves the compare value unchanged and sets the error flag (address 0 bit 7). A write to address 0 with bit 7 at 1 clears the flag.
- R8: The value in address 3 has no effect on which edges are counted.
- R9: A new pulseIn level that is first sampled at clock edge k changes the count at edge k+2, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous external pulse input |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational from regAddr) |
| matchIrq | output | 1 | One-cycle compare-match interrupt |

## Verification
A register write takes effect on the clock edge that samples regWe, so its readback is due in the following cycle. A pulse level sampled at edge k moves the count at edge k+2, and matchIrq rises on the same edge that clears the count. The bench drives every input just after the falling clock edge. Its behavioural model advances on each rising edge, and matchIrq and the read data are compared at the next falling edge, so each result is checked one full register stage after its cause.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef struct packed {
    logic step;
    logic wrCmpLo;
    logic wrCmpHi;
  } dpStrobe_t;
endpackage

// File: rtl/cec_ctrl.sv
module cec_ctrl
  import cec_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pulseIn,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWdata,
  input  logic [2*BYTE_W-1:0] countVal,
  input  logic [2*BYTE_W-1:0] cmpVal,
  output dpStrobe_t           strobe,
  output logic [BYTE_W-1:0]   regRdata,
  output logic                enLo,
  output logic                enHi,
  output logic                casc,
  output logic                active
);
  localparam logic [ADDR_W-1:0] A_CTRL_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EDGE_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EDGE_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMP_LO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CMP_HI  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'(7);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   edgeRise;
  logic [BYTE_W-1:0]      edgeHiQ;
  logic                   errFlag;
  logic                   seenRise;
  logic                   seenFall;
  logic                   cmpWrite;

  // synchroniser chain and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pulseIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign seenRise = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign seenFall = ~syncQ[SYNC_STAGES-1] & prevQ;
  assign active   = enLo & enHi & casc;
  assign cmpWrite = regWe & ((regAddr == A_CMP_LO) | (regAddr == A_CMP_HI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enLo     <= 1'b0;
      enHi     <= 1'b0;
      casc     <= 1'b0;
      edgeRise <= 1'b0;
      edgeHiQ  <= '0;
      errFlag  <= 1'b0;
    end else if (regWe) begin
      unique case (regAddr)
        A_CTRL_LO: begin
          enLo <= regWdata[0] & enHi;
          if (regWdata[BYTE_W-1]) errFlag <= 1'b0;
        end
        A_CTRL_HI: begin
          enHi <= regWdata[0];
          casc <= regWdata[1];
        end
        A_EDGE_LO: edgeRise <= regWdata[0];
        A_EDGE_HI: edgeHiQ  <= regWdata;
        default: if (cmpWrite && active) errFlag <= 1'b1;
      endcase
    end
  end

  always_comb begin
    strobe.step    = active & (edgeRise ? seenRise : seenFall);
    strobe.wrCmpLo = cmpWrite & ~active & (regAddr == A_CMP_LO);
    strobe.wrCmpHi = cmpWrite & ~active & (regAddr == A_CMP_HI);
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CTRL_LO: begin
        regRdata[0]        = enLo;
        regRdata[BYTE_W-1] = errFlag;
      end
      A_CTRL_HI: regRdata[1:0] = {casc, enHi};
      A_EDGE_LO: regRdata[0]   = edgeRise;
      A_EDGE_HI: regRdata      = edgeHiQ;
      A_CMP_LO:  regRdata      = cmpVal[BYTE_W-1:0];
      A_CMP_HI:  regRdata      = cmpVal[2*BYTE_W-1:BYTE_W];
      A_CNT_LO:  regRdata      = countVal[BYTE_W-1:0];
      A_CNT_HI:  regRdata      = countVal[2*BYTE_W-1:BYTE_W];
      default:   regRdata      = '0;
    endcase
  end
endmodule

// File: rtl/cec_datapath.sv
module cec_datapath
  import cec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [2*BYTE_W-1:0] countVal,
  output logic [2*BYTE_W-1:0] cmpVal,
  output logic                matchIrq
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int LANES = CNT_W / BYTE_W;

  logic hit;

  // one compare byte lane per channel
  for (genvar lane = 0; lane < LANES; lane++) begin : g_cmpLane
    logic laneWr;
    assign laneWr = (lane == 0) ? strobe.wrCmpLo : strobe.wrCmpHi;
    always_ff @(posedge clk) begin
      if (!rstN) cmpVal[lane*BYTE_W +: BYTE_W] <= '0;
      else if (laneWr) cmpVal[lane*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  assign hit = (countVal == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      matchIrq <= 1'b0;
    end else begin
      matchIrq <= strobe.step & hit;
      if (strobe.step) countVal <= hit ? '0 : countVal + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cascade_event_counter.sv
module cascade_event_counter
  import cec_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              matchIrq
);
  localparam int CNT_W = 2 * BYTE_W;

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] cmpVal;
  logic             enLo;
  logic             enHi;
  logic             casc;
  logic             active;

  cec_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .countVal(countVal), .cmpVal(cmpVal), .strobe(strobe),
    .regRdata(regRdata), .enLo(enLo), .enHi(enHi), .casc(casc), .active(active)
  );

  cec_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWdata),
    .countVal(countVal), .cmpVal(cmpVal), .matchIrq(matchIrq)
  );
endmodule

// File: rtl/cec_checker.sv
module cec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             matchIrq,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] cmpVal,
  input logic             enLo,
  input logic             enHi,
  input logic             active
);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |=> !matchIrq);

  assert_irq_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |-> (countVal == '0));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> $stable(countVal));

  assert_start_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enLo) |-> $past(enHi));

  assert_cmp_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    active |=> $stable(cmpVal));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (countVal != $past(countVal)) |->
      ((countVal == $past(countVal) + CNT_W'(1)) || (countVal == '0)));
endmodule

bind cascade_event_counter cec_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .matchIrq(matchIrq), .countVal(countVal),
  .cmpVal(cmpVal), .enLo(enLo), .enHi(enHi), .active(active)
);

// File: tb/cascade_event_counter_tb_top.sv
`timescale 1ns/1ps
module cascade_event_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       matchIrq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;

  // behavioural reference state
  bit        mS1, mS2, mPrev;
  bit        mEnLo, mEnHi, mCasc, mEdgeRise, mErr, mIrq;
  bit [7:0]  mEdgeHi;
  bit [15:0] mCmp;
  int        mCount;

  always #5 clk = ~clk;

  cascade_event_counter dut_i (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .matchIrq(matchIrq)
  );

  always @(posedge clk) begin
    bit edgeOk, act;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mEnLo = 0; mEnHi = 0; mCasc = 0;
      mEdgeRise = 0; mErr = 0; mIrq = 0; mEdgeHi = 0; mCmp = 0; mCount = 0;
    end else begin
      act    = mEnLo && mEnHi && mCasc;
      edgeOk = mEdgeRise ? (mS2 && !mPrev) : (!mS2 && mPrev);
      mIrq = 0;
      if (act && edgeOk) begin
        if (mCount == int'(mCmp)) begin mCount = 0; mIrq = 1; end
        else mCount = (mCount + 1) % 65536;
      end
      mPrev = mS2; mS2 = mS1; mS1 = pulseIn;
      if (regWe) begin
        case (regAddr)
          3'd0: begin mEnLo = regWdata[0] && mEnHi; if (regWdata[7]) mErr = 0; end
          3'd1: begin mEnHi = regWdata[0]; mCasc = regWdata[1]; end
          3'd2: mEdgeRise = regWdata[0];
          3'd3: mEdgeHi = regWdata;
          3'd4: if (act) mErr = 1; else mCmp[7:0] = regWdata;
          3'd5: if (act) mErr = 1; else mCmp[15:8] = regWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {mErr, 6'd0, mEnLo};
      3'd1: return {6'd0, mCasc, mEnHi};
      3'd2: return {7'd0, mEdgeRise};
      3'd3: return mEdgeHi;
      3'd4: return mCmp[7:0];
      3'd5: return mCmp[15:8];
      3'd6: return mCount[7:0];
      default: return mCount[15:8];
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (matchIrq) irqSeen++;
      check("R6 irq", int'(matchIrq), int'(mIrq));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input int exp);
    @(negedge clk); regWe = 0; regAddr = a; #1;
    check(req, int'(regRdata), int'(modelRead(a)));
    if (exp >= 0) check(req, int'(regRdata), exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulseIn = 1; @(negedge clk);
      @(negedge clk); pulseIn = 0; @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 0);

    // R2 lower enable refused while upper enable is 0
    wr(3'd0, 8'h01);
    rd("R2", 3'd0, 0);

    // R4 rising edges, R6 N=3
    wr(3'd4, 8'h03); wr(3'd5, 8'h00); wr(3'd2, 8'h01);
    wr(3'd1, 8'h03); wr(3'd0, 8'h01);
    rd("R2", 3'd0, 1);
    irqSeen = 0;
    pulses(9);
    check("R6 irq count", irqSeen, 2);
    rd("R4", 3'd6, 1);

    // R7 compare write while active
    wr(3'd4, 8'h77);
    rd("R7", 3'd4, 8'h03);
    rd("R7", 3'd0, 8'h81);
    wr(3'd0, 8'h81);
    rd("R7", 3'd0, 8'h01);

    // R3 stop: lower first, then upper; count holds
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    pulses(3);
    rd("R3", 3'd6, 1);
    // cascade bit clear with both enables: still held
    wr(3'd1, 8'h01); wr(3'd0, 8'h01);
    pulses(2);
    rd("R3", 3'd6, 1);
    wr(3'd0, 8'h00);

    // R4 falling edge; R8 upper edge select has no effect
    wr(3'd2, 8'h00); wr(3'd3, 8'h01); wr(3'd4, 8'hFF);
    wr(3'd1, 8'h03); wr(3'd0, 8'h01);
    @(negedge clk); pulseIn = 1; repeat (4) @(negedge clk);
    rd("R8", 3'd6, 1);
    pulseIn = 0; repeat (4) @(negedge clk);
    rd("R4", 3'd6, 2);

    // R5 16-bit count with carry, N = 0105h
    wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd2, 8'h01);
    wr(3'd4, 8'h05); wr(3'd5, 8'h01);
    wr(3'd0, 8'h01);
    irqSeen = 0;
    pulses(254);
    rd("R5", 3'd6, 0); rd("R5", 3'd7, 1);
    pulses(5);
    rd("R5", 3'd6, 5);
    check("R6 no early irq", irqSeen, 0);
    pulses(1);
    check("R6 irq at N+1", irqSeen, 1);
    rd("R6", 3'd7, 0); rd("R6", 3'd6, 0);

    // R6 N = 0: pulse on every counted edge
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd0, 8'h01);
    irqSeen = 0;
    pulses(4);
    check("R6 N=0", irqSeen, 4);

    // R9 latency: set N large, watch count edge by edge
    wr(3'd0, 8'h00); wr(3'd4, 8'h40); wr(3'd0, 8'h01);
    @(negedge clk); regAddr = 3'd6; #1; base = int'(regRdata);
    pulseIn = 1;
    @(negedge clk); #1; check("R9 k", int'(regRdata), base);
    @(negedge clk); #1; check("R9 k+1", int'(regRdata), base);
    @(negedge clk); #1; check("R9 k+2", int'(regRdata), base + 1);
    pulseIn = 0;
    repeat (4) @(negedge clk);
    rd("R9", 3'd6, base + 1);

    finishSim();
  end
endmodule